// File: doc/BRIEF.md
# Radix-4 Recoded Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns their full 2N-bit product. It is purely combinational. The product is valid once the inputs have settled, with no clock and no latency. It sits inside a larger datapath that registers its operands and result.

A control stage recodes the multiplier (operand B) in radix 4. It slides a three-bit window over B, two bits at a time. For each row it produces three strobes: take the multiplicand once, take it twice, and negate. A datapath stage uses these strobes to form one partial product per row from the multiplicand (operand A). Negative rows are formed by bitwise inversion plus a one added at the row's lowest bit. This replaces both a 3A multiple and full sign extension.

Sign extension is folded into two pieces. Each row carries one inverted-sign bit above its top. One correction word, computed when the design is elaborated, collects every constant term. All rows, the negate ones and the correction word pass through a chain of carry-save adders. A single carry-propagate adder then resolves the last sum and carry words.

Top module: `radix4_mult`

## Requirements
- R1: `prodOut` equals the unsigned product `opA * opB` over its full 2N bits, for every pair of N-bit operands.
- R2: The multiplier is extended with a zero below bit 0 and two zeros above bit N-1. Row i (0 to N/2) reads the window {B[2i+1], B[2i], B[2i-1]}, which gives N/2+1 rows. The top row is never negative, so a set top bit of B still yields the correct product.
- R3: Window values map to multiples as follows: 000 gives 0, 001 and 010 give +A, 011 gives +2A, 100 gives -2A, 101 and 110 give -A, and 111 gives a negated zero. The take-once and take-twice strobes are never both high.
- R4: A negated row is the inverted N+1-bit multiple plus a one at that row's least significant position (bit 2i). A row with neither strobe high contributes exactly zero once its negate one is counted.
- R5: The sign of each row is represented only by its inverted sign bit at position 2i+N+1 plus one shared constant word. That word equals the sum, modulo 2^(2N), of minus 2^(N+1+2i) over all rows. The result stays exact when many rows are negative at once, for example with B alternating 1010.
- R6: With N = 16, 12 × 5 gives 60, and each single-bit multiplier 2^k gives A shifted left by k.
- R7: All-ones times all-ones gives 2^(2N) - 2^(N+1) + 1, which is 0xFFFE0001 for N = 16.
- R8: If either operand is zero, the product is zero.
- R9: N is even and at least 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | N | Unsigned multiplicand |
| opB | input | N | Unsigned multiplier, recoded in radix 4 |
| prodOut | output | 2N | Unsigned product |

## Verification
Multipliers of the form 1010 repeated make nearly every row negative. Multipliers of the form 0101 repeated make every row +A. Comparing the two separates an error in the inversion and one-injection path from an error in the positive select path. Single-bit multipliers sweep each window position and the zero-extended top row. The operand pair 12 × 5, the all-ones pair and zero operands pin down the constant-word arithmetic and the idle rows. Random pairs then cover the mixed window combinations, with each result compared against a plain integer product on every clock.

// File: rtl/radix4_mult_pkg.sv
package radix4_mult_pkg;
  // Strobes from the recoder to the partial-product selectors.
  typedef struct packed {
    logic pickOne;
    logic pickTwo;
    logic negate;
  } boothCtlT;
endpackage

// File: rtl/radix4_booth_ctl.sv
module radix4_booth_ctl
  import radix4_mult_pkg::*;
#(
  parameter int N = 16,
  localparam int Rows = N / 2 + 1
) (
  input  logic [N-1:0]            mplier,
  output boothCtlT [Rows-1:0]     ctl
);
  // extB[k+1] holds B[k]; one zero below, two zeros above.
  localparam int ExtW = N + 3;
  logic [ExtW-1:0] extB;
  assign extB = {2'b00, mplier, 1'b0};

  for (genvar i = 0; i < Rows; i++) begin : g_enc
    logic [2:0] win;
    logic oneSel, twoSel, negSel;
    assign win = extB[2*i+2 : 2*i];

    always_comb begin
      oneSel = win[1] ^ win[0];
      twoSel = (win[2] & ~win[1] & ~win[0]) | (~win[2] & win[1] & win[0]);
      negSel = win[2];
      // R3: never both multiples at once
      p_sel_exclusive_r3: assert ($onehot0({oneSel, twoSel}))
        else $error("both multiples selected in row %0d", i);
      // R3: uniform windows select no multiple
      if (win == 3'b000 || win == 3'b111)
        p_zero_window_r3: assert (!oneSel && !twoSel)
          else $error("uniform window selected a multiple");
    end

    assign ctl[i] = '{pickOne: oneSel, pickTwo: twoSel, negate: negSel};

    if (i == Rows - 1) begin : g_top
      // R2: zero extension keeps the top row non-negative
      always_comb p_top_row_pos_r2: assert (!negSel)
        else $error("top row negated");
    end
  end
endmodule

// File: rtl/radix4_booth_dp.sv
module radix4_booth_dp
  import radix4_mult_pkg::*;
#(
  parameter int N = 16,
  localparam int Rows = N / 2 + 1,
  localparam int ProdW = 2 * N
) (
  input  logic [N-1:0]         mcand,
  input  boothCtlT [Rows-1:0]  ctl,
  output logic [ProdW-1:0]     product
);
  // Shared correction word: sum of -2^(N+1+2i) for all rows, mod 2^ProdW.
  function automatic logic [ProdW-1:0] foldSign();
    logic [ProdW-1:0] acc;
    acc = '0;
    for (int i = 0; i < Rows; i++)
      if (N + 1 + 2 * i < ProdW)
        acc = acc - ({{(ProdW-1){1'b0}}, 1'b1} << (N + 1 + 2 * i));
    return acc;
  endfunction
  localparam logic [ProdW-1:0] SignConst = foldSign();

  logic [ProdW-1:0] rowTerm [Rows];
  logic [ProdW-1:0] negRow;

  for (genvar i = 0; i < Rows; i++) begin : g_sel
    logic [N:0] mult, pp;
    always_comb begin
      mult = ({(N+1){ctl[i].pickOne}} & {1'b0, mcand})
           | ({(N+1){ctl[i].pickTwo}} & {mcand, 1'b0});
      pp   = mult ^ {(N+1){ctl[i].negate}};
      // R4: an idle row is all-zero or all-ones (cancelled by its injected one)
      if (!ctl[i].pickOne && !ctl[i].pickTwo)
        p_idle_row_r4: assert (pp == '0 || pp == '1)
          else $error("idle row %0d not uniform", i);
    end
    assign rowTerm[i] = {{(ProdW-N-2){1'b0}}, ~ctl[i].negate, pp} << (2 * i);
  end

  always_comb begin
    negRow = '0;
    for (int i = 0; i < Rows; i++) negRow[2*i] = ctl[i].negate;
  end

  // Carry-save chain: Rows+2 operands reduced to two words by Rows stages.
  logic [ProdW-1:0] sumW [Rows];
  logic [ProdW-1:0] carW [Rows];

  for (genvar k = 0; k < Rows; k++) begin : g_csa
    logic [ProdW-1:0] inX, inY, inZ;
    if (k == 0) begin : g_first
      assign inX = rowTerm[0];
      assign inY = rowTerm[1];
      assign inZ = rowTerm[2];
    end else begin : g_next
      assign inX = sumW[k-1];
      assign inY = carW[k-1];
      if (k + 2 < Rows) begin : g_row
        assign inZ = rowTerm[k+2];
      end else if (k + 2 == Rows) begin : g_neg
        assign inZ = negRow;
      end else begin : g_const
        assign inZ = SignConst;
      end
    end
    assign sumW[k] = inX ^ inY ^ inZ;
    assign carW[k] = ((inX & inY) | (inX & inZ) | (inY & inZ)) << 1;
  end

  assign product = sumW[Rows-1] + carW[Rows-1];

  // R8: zero multiplicand must give zero product
  always_comb
    if (mcand == '0)
      p_zero_mcand_r8: assert (product == '0)
        else $error("nonzero product from zero multiplicand");
endmodule

// File: rtl/radix4_mult.sv
module radix4_mult
  import radix4_mult_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  output logic [2*N-1:0] prodOut
);
  localparam int Rows = N / 2 + 1;

  if (N % 2 != 0 || N < 4) begin : g_bad_width
    initial $error("N must be even and at least 4 (R9)");
  end

  boothCtlT [Rows-1:0] rowCtl;

  radix4_booth_ctl #(.N(N)) u_ctl (
    .mplier (opB),
    .ctl    (rowCtl)
  );

  radix4_booth_dp #(.N(N)) u_dp (
    .mcand   (opA),
    .ctl     (rowCtl),
    .product (prodOut)
  );
endmodule

// File: tb/test_radix4_mult.sv
module test_radix4_mult;
  localparam int N = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] opA = '0, opB = '0;
  logic [2*N-1:0] prodOut;
  int nRun = 0, nFail = 0, wdog = 0;

  always #2 clk = ~clk;

  radix4_mult #(.N(N)) i_radix4_mult (.opA(opA), .opB(opB), .prodOut(prodOut));

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    wdog <= wdog + 1;
    if (wdog > 100000) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung, expected completion");
      finishRun();
    end
  end

  task automatic tryPair(input logic [N-1:0] a, input logic [N-1:0] b, input string req);
    logic [2*N-1:0] expv;
    @(posedge clk);
    opA <= a; opB <= b;
    @(negedge clk);
    expv = (2*N)'(64'(a) * 64'(b));
    nRun++;
    if (prodOut !== expv) begin
      nFail++;
      $display("FAIL %s: %0h*%0h actual %0h expected %0h", req, a, b, prodOut, expv);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R8: idle zero inputs at start
    @(negedge clk);
    nRun++;
    if (prodOut !== '0) begin
      nFail++;
      $display("FAIL R8: start actual %0h expected 0", prodOut);
    end
    tryPair(16'd12, 16'd5, "R6");
    tryPair('1, '1, "R7");
    tryPair(16'h0000, 16'hBEEF, "R8");
    tryPair(16'h1234, 16'h0000, "R8");
    tryPair(16'hFFFF, 16'hAAAA, "R5");
    tryPair(16'h8001, 16'hAAAA, "R5");
    tryPair(16'hFFFF, 16'h5555, "R4");
    tryPair(16'h7FFF, 16'h5555, "R4");
    tryPair(16'hFFFF, 16'h8000, "R2");
    tryPair(16'hFFFF, 16'hC000, "R2");
    tryPair(16'hABCD, 16'h0003, "R3");
    tryPair(16'hABCD, 16'h0006, "R3");
    tryPair(16'hABCD, 16'h0007, "R3");
    tryPair(16'hABCD, 16'hEEEE, "R3");
    for (int k = 0; k < N; k++) tryPair(16'hD2C5, 16'(1) << k, "R6");
    for (int k = 0; k < 400; k++) tryPair(16'($urandom), 16'($urandom), "R1");
    finishRun();
  end
endmodule